// File: doc/BRIEF.md
# Buffered Cycle-Stealing DMA Controller

A single-channel block that moves a programmed number of words between an I/O device and memory without processor involvement. Software loads a source address, a destination address and a word count, then writes the control register with a direction and a start bit. The controller asks the processor for the bus with a hold request. It uses the memory port only while hold acknowledge is granted.

A small word buffer sits between the device side and the memory side. In the device-to-memory direction, device words keep arriving while the bus is withheld. When the processor grants the bus, the buffered words are written out one single-beat cycle at a time. The processor may lend the bus only for a few idle machine cycles and take it back at any moment. The controller keeps its addresses and remaining count, and carries on from the same word at the next grant. Completion raises a sticky done flag that drives the interrupt output.

Top module: `dma_steal_ctrl`

## Requirements
- R1: Configuration writes select a register with `cfg_sel`: 0 source address, 1 destination address, 2 word count, 3 control. In control, bit 0 is the direction (0 device-to-memory, 1 memory-to-device), bit 1 starts a transfer and bit 2 clears done. Address and count writes, and start, have no effect while a transfer is running.
- R2: `mem_valid` is high only if `hold_ack` was high in the previous cycle. It is low in the cycle after any cycle with `hold_ack` low. `hold_req` is high whenever `mem_valid` is high.
- R3: In device-to-memory mode, `dev_ack` accepts device words while the buffer (DEPTH words) has room, even with no bus grant. It stays low when the buffer is full or when all counted words have been taken.
- R4: In device-to-memory mode, the k-th memory write (`mem_we`=1) goes to destination+k with the k-th device word. A beat completes only in a cycle with `mem_valid`, `mem_ready` and `hold_ack` all high.
- R5: When the grant is revoked and restored any number of times, every word is written exactly once, in order, and the transfer resumes at the next word.
- R6: In memory-to-device mode, the controller reads (`mem_we`=0) from source+k in order. It hands the words to the device in the same order on `dev_rdata` when `dev_req` and `dev_ack` are both high.
- R7: After the last word, `irq` goes high and stays high until a control write with bit 1 or bit 2 set.
- R8: A start with a word count of 0 raises `irq` at the next edge and never raises `hold_req`.
- R9: A beat with `mem_ready` low and `hold_ack` high keeps `mem_valid`, `mem_addr` and `mem_wdata` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| dev_req | input | 1 | Device request: word offered or wanted |
| dev_ack | output | 1 | Controller accepts or supplies a word |
| dev_wdata | input | DATA_W | Word from the device |
| dev_rdata | output | DATA_W | Word to the device |
| hold_req | output | 1 | Bus ownership request to the processor |
| hold_ack | input | 1 | Bus ownership grant from the processor |
| mem_valid | output | 1 | Memory beat in progress |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_ready | input | 1 | Memory completes the beat |
| irq | output | 1 | Sticky transfer-done interrupt |

## Verification
The bench revokes and regrants the bus at random while the memory stalls at random. This targets a controller that counts an abandoned beat, which would skip a word, or repeats one after a regrant, which would misalign the address sequence. It first withholds the grant entirely with a device pushing every cycle. A design that overruns the buffer would show extra accepted words, and one that waits for the bus would accept none. It also rewrites the destination mid-transfer, starts with a zero count and checks that done survives idle cycles. A design that honours writes while busy, requests the bus for nothing or drops done early would each be caught there.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dir_e;

    localparam int CTRL_DIR_BIT = 0;
    localparam int CTRL_GO_BIT  = 1;
    localparam int CTRL_CLR_BIT = 2;

    typedef struct packed {
        logic load_src;
        logic load_dst;
        logic load_cnt;
        logic go;
        logic clr;
        dir_e dir;
    } cfg_cmd_t;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_steal_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output cfg_cmd_t         cmd
);
    reg_sel_e sel;

    always_comb begin
        sel          = reg_sel_e'(cfg_sel);
        cmd          = '0;
        cmd.load_src = cfg_we && (sel == SEL_SRC);
        cmd.load_dst = cfg_we && (sel == SEL_DST);
        cmd.load_cnt = cfg_we && (sel == SEL_CNT);
        cmd.go       = cfg_we && (sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];
        cmd.clr      = cfg_we && (sel == SEL_CTRL) && cfg_wdata[CTRL_CLR_BIT];
        cmd.dir      = dir_e'(cfg_wdata[CTRL_DIR_BIT]);
    end
endmodule

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 push,
    input  logic [DATA_W-1:0]                    push_data,
    input  logic                                 pop,
    output logic [DATA_W-1:0]                    head,
    output logic [$clog2(DEPTH+1)-1:0]           level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.lvl != '0);
        do_push = push && ((st_q.lvl != LVL_W'(DEPTH)) || do_pop);
        if (do_push) st_d.wr_ptr = bump(st_q.wr_ptr);
        if (do_pop)  st_d.rd_ptr = bump(st_q.rd_ptr);
        st_d.lvl = st_q.lvl + LVL_W'(do_push) - LVL_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[st_q.wr_ptr] <= push_data;
    end

    assign head  = slot_q[st_q.rd_ptr];
    assign level = st_q.lvl;
endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dev_req,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              irq
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic              active;
        dir_e              dir;
        logic              done;
        logic              beat;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] fill;
    } ctl_st_t;

    ctl_st_t st_q, st_d;
    cfg_cmd_t cmd;

    logic              fifo_push, fifo_pop;
    logic [DATA_W-1:0] fifo_in, fifo_head;
    logic [LVL_W-1:0]  lvl, lvl_nx;
    logic              to_mem, beat_done, dev_xfer, ack_c, work_nx;

    dma_cfg_decode #(.REG_W(ADDR_W)) u_dec (
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cmd       (cmd)
    );

    dma_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_in),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (lvl)
    );

    always_comb begin
        to_mem    = (st_q.dir == DIR_DEV2MEM);
        ack_c     = st_q.active &&
                    (to_mem ? ((st_q.fill != '0) && (lvl < FULL_LVL)) : (lvl != '0));
        dev_xfer  = dev_req && ack_c;
        beat_done = st_q.beat && mem_ready && hold_ack;
        fifo_push = to_mem ? dev_xfer  : beat_done;
        fifo_pop  = to_mem ? beat_done : dev_xfer;
        fifo_in   = to_mem ? dev_wdata : mem_rdata;
        lvl_nx    = lvl + LVL_W'(fifo_push) - LVL_W'(fifo_pop);

        st_d    = st_q;
        work_nx = 1'b0;
        if (st_q.active) begin
            if (to_mem) begin
                if (dev_xfer) begin
                    st_d.src  = st_q.src + 1'b1;
                    st_d.fill = st_q.fill - 1'b1;
                end
                if (beat_done) begin
                    st_d.dst = st_q.dst + 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                end
                work_nx = (lvl_nx != '0);
            end else begin
                if (beat_done) begin
                    st_d.src  = st_q.src + 1'b1;
                    st_d.fill = st_q.fill - 1'b1;
                end
                if (dev_xfer) begin
                    st_d.dst = st_q.dst + 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                end
                work_nx = (st_d.fill != '0) && (lvl_nx < FULL_LVL);
            end
            // a dropped grant abandons the beat; nothing advances for it
            st_d.beat = hold_ack && work_nx && (st_d.cnt != '0);
            if (st_d.cnt == '0) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                st_d.beat   = 1'b0;
            end
        end else begin
            st_d.beat = 1'b0;
            if (cmd.load_src) st_d.src = cfg_wdata;
            if (cmd.load_dst) st_d.dst = cfg_wdata;
            if (cmd.load_cnt) st_d.cnt = cfg_wdata;
            if (cmd.clr)      st_d.done = 1'b0;
            if (cmd.go) begin
                st_d.dir  = cmd.dir;
                st_d.fill = st_q.cnt;
                if (st_q.cnt == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.done   = 1'b0;
                    st_d.active = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hold_req  = st_q.active &&
                    (to_mem ? (lvl != '0) : ((st_q.fill != '0) && (lvl < FULL_LVL)));
        dev_ack   = ack_c;
        dev_rdata = (!to_mem && ack_c) ? fifo_head : '0;
        mem_valid = st_q.beat;
        mem_we    = st_q.beat && to_mem;
        mem_addr  = st_q.beat ? (to_mem ? st_q.dst : st_q.src) : '0;
        mem_wdata = (st_q.beat && to_mem) ? fifo_head : '0;
        irq       = st_q.done;
    end
endmodule

// File: rtl/dma_steal_ctrl_chk.sv
module dma_steal_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              irq
);
    logic ctrl_release;
    assign ctrl_release = cfg_we && (cfg_sel == 2'd3) && (cfg_wdata[1] || cfg_wdata[2]);

    p_bus_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack |=> !mem_valid);

    p_bus_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> hold_req);

    p_beat_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && hold_ack) |=>
        (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_release) |=> irq);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!hold_req && !mem_valid));
endmodule

bind dma_steal_ctrl dma_steal_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq)
);

// File: tb/dma_steal_ctrl_bench.sv
module dma_steal_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dev_req = 1'b0;
    logic          dev_ack;
    logic [DW-1:0] dev_wdata = '0;
    logic [DW-1:0] dev_rdata;
    logic          hold_req;
    logic          hold_ack = 1'b0;
    logic          mem_valid, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ready = 1'b0;
    logic          irq;

    always #10 clk = ~clk;

    dma_steal_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dma_steal_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .hold_req(hold_req), .hold_ack(hold_ack), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return (a * 16'd5) ^ 16'h3c3c;
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    int checks = 0, errors = 0, cycles = 0;
    logic [31:0] exp_q [$];
    bit   run_w = 0, run_r = 0;
    int   dev_total = 0, dev_idx = 0, dev_got = 0, reads = 0, writes = 0;
    int   ack_pct = 0, req_pct = 0, rdy_pct = 0;
    int   bus_bad = 0, stall_bad = 0, order_bad = 0;
    bit   hold_seen = 0, prev_ack = 0, prev_stall = 0;
    logic [AW-1:0] dst_base = '0, src_base = '0, prev_addr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void drive_word(input logic [DW-1:0] d);
        exp_q.push_back({dst_base + AW'(dev_idx), d});
        dev_idx++;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            hold_ack  = hold_req && ($urandom_range(99) < ack_pct);
            mem_ready = ($urandom_range(99) < rdy_pct);
            if (run_w) begin
                dev_req   = (dev_idx < dev_total) && ($urandom_range(99) < req_pct);
                dev_wdata = 16'h5a00 + DW'(dev_idx * 3);
            end else if (run_r) begin
                dev_req = ($urandom_range(99) < req_pct);
            end else begin
                dev_req = 1'b0;
            end
            #1;
            if (hold_req) hold_seen = 1;
            if (mem_valid && !prev_ack) bus_bad++;
            if (prev_stall && !(mem_valid && mem_addr == prev_addr)) stall_bad++;
            prev_stall = mem_valid && !mem_ready && hold_ack;
            prev_addr  = mem_addr;
            if (mem_valid && mem_ready && hold_ack) begin
                if (run_w) begin
                    logic [31:0] e;
                    if (exp_q.size() == 0) begin
                        check(0, "R4", "write with empty scoreboard", mem_addr, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(mem_we && {mem_addr, mem_wdata} == e, "R4",
                              "write addr/data", {mem_addr, mem_wdata}, e);
                    end
                    writes++;
                end else begin
                    if (mem_we || mem_addr != src_base + AW'(reads)) order_bad++;
                    reads++;
                end
            end
            if (dev_req && dev_ack) begin
                if (run_w) drive_word(dev_wdata);
                else begin
                    check(dev_rdata == mem_fn(src_base + AW'(dev_got)), "R6",
                          "device read word", dev_rdata, mem_fn(src_base + AW'(dev_got)));
                    dev_got++;
                end
            end
            prev_ack = hold_ack;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        #2;
        check(irq == 1'b1, req, "irq after transfer", irq, 1);
        run_w = 0; run_r = 0;
    endtask

    task automatic start_write(input int cnt, input logic [AW-1:0] dst);
        dst_base = dst; dev_total = cnt; dev_idx = 0; writes = 0;
        bus_bad = 0; stall_bad = 0;
        cfg_write(2'd0, 16'h0020);
        cfg_write(2'd1, dst);
        cfg_write(2'd2, AW'(cnt));
        run_w = 1;
        cfg_write(2'd3, 16'h0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!hold_req && !mem_valid && !irq && !dev_ack, "R2", "reset outputs",
              {hold_req, mem_valid, irq, dev_ack}, 0);
        rst_n = 1'b1;

        // R8: zero count
        hold_seen = 0;
        cfg_write(2'd2, 16'd0);
        cfg_write(2'd3, 16'h0002);
        #2;
        check(irq == 1'b1, "R8", "zero count done at once", irq, 1);
        repeat (10) @(negedge clk);
        #2;
        check(hold_seen == 0, "R8", "no hold request on zero count", hold_seen, 0);

        // R3: buffer fills without a grant, then device is stalled
        ack_pct = 0; req_pct = 100; rdy_pct = 70;
        start_write(12, 16'h0100);
        #2;
        check(irq == 1'b0, "R7", "start clears done", irq, 0);
        repeat (12) @(negedge clk);
        #2;
        check(dev_idx == DEPTH, "R3", "words buffered without grant", dev_idx, DEPTH);
        check(dev_ack == 1'b0, "R3", "device stalled on full buffer", dev_ack, 0);
        check(writes == 0, "R2", "no writes without grant", writes, 0);
        // R1: writes while busy are ignored
        cfg_write(2'd1, 16'h0777);
        ack_pct = 40; req_pct = 60;
        wait_done("R4");
        check(writes == 12 && exp_q.size() == 0, "R4", "all words written once",
              writes, 12);
        check(bus_bad == 0, "R2", "beats only after grant", bus_bad, 0);
        check(stall_bad == 0, "R9", "beat held while waiting", stall_bad, 0);
        check(dev_idx == 12, "R1", "device words taken (busy writes ignored)", dev_idx, 12);
        repeat (20) @(negedge clk);
        #2;
        check(irq == 1'b1, "R7", "done stays set", irq, 1);
        cfg_write(2'd3, 16'h0004);
        #2;
        check(irq == 1'b0, "R7", "clear bit drops done", irq, 0);

        // R5: heavy revoke pattern
        ack_pct = 15; req_pct = 50; rdy_pct = 50;
        start_write(9, 16'h0a40);
        wait_done("R5");
        check(writes == 9 && exp_q.size() == 0, "R5", "resume after revokes", writes, 9);
        check(bus_bad == 0, "R5", "no beat after revoke", bus_bad, 0);

        // R6: memory to device
        cfg_write(2'd3, 16'h0004);
        src_base = 16'h0300; dev_got = 0; reads = 0; order_bad = 0;
        ack_pct = 50; req_pct = 40; rdy_pct = 60;
        cfg_write(2'd0, src_base);
        cfg_write(2'd2, 16'd10);
        run_r = 1;
        cfg_write(2'd3, 16'h0003);
        wait_done("R6");
        check(dev_got == 10, "R6", "words delivered", dev_got, 10);
        check(reads == 10 && order_bad == 0, "R6", "reads in order", reads, 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule